// File: doc/BRIEF.md
# Endpoint Buffer Ready Notifier

This block connects a set of internal endpoint buffers to an external host processor on a synchronous SRAM-style bus. Each buffer has a ready flag. The buffer side raises the flag with a one-cycle pulse when the buffer holds data to read or has room to write. The host clears the flag by writing a 1 to that flag's bit in a status word.

The host chooses how it is told that a buffer is ready. In interrupt mode, a maskable interrupt line is raised. In DMA mode, a DMA-slave request line is raised. In both modes the host then polls the status word to learn which buffers are ready. It moves the data through a buffer window in its address space, and the block decodes that window into an endpoint select, a word index and read/write strobes for the buffer storage.

Top module: `ep_ready_notifier`

## Requirements
- R1: After reset all ready flags are 0 and all interrupt enables are 0. The notification mode is interrupt, and `irq_o` and `dma_req_o` are both low.
- R2: A 1 on bit n of `ready_set_i` in a cycle sets ready flag n. The flag reads back as bit n of the status word.
- R3: A host write to the status word clears each flag whose data bit is 1 and leaves the flags whose data bit is 0 unchanged.
- R4: When a buffer-side set and a host clear hit the same flag in the same cycle, the flag ends up set.
- R5: In interrupt mode, `irq_o` is high in the cycle after some ready flag whose enable bit is 1 is set. It stays high until no enabled flag is set. A set flag with a 0 enable bit never raises `irq_o`. `dma_req_o` stays low in this mode.
- R6: In DMA mode, `dma_req_o` is high in the cycle after any ready flag is set, whatever the enable bits hold, and stays high until all flags are clear. `irq_o` stays low in this mode.
- R7: Register map, word addresses with address bit 9 = 0:
  - 0x000 is the control word. Bit 0 selects the mode: 0 = interrupt, 1 = DMA.
  - 0x001 is the interrupt enable word. Bit n = 1 enables flag n.
  - 0x002 is the status word.
  - Any other address with bit 9 = 0 reads as 0.
  - Read data appears on `rdata_o` the cycle after the read access and holds until the next read.
- R8: Address bit 9 = 1 selects the buffer window. Bits 8:5 give the endpoint and bits 4:0 give the word. During such an access:
  - `buf_sel_o` is one-hot on that endpoint and `buf_word_o` carries the word.
  - `buf_we_o` or `buf_re_o` follows the access direction.
  - A read returns `buf_rdata_i` on `rdata_o` in the next cycle.
- R9: Accesses to the buffer window, and to unmapped register addresses, leave the control word, the enable word and the ready flags unchanged. Outside the buffer window, `buf_sel_o`, `buf_we_o` and `buf_re_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Bus access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 10 | Word address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Registered read data |
| ready_set_i | input | 16 | Per-buffer ready pulse from the buffer side |
| buf_sel_o | output | 16 | One-hot endpoint select for the buffer window |
| buf_word_o | output | 5 | Word index inside the selected buffer |
| buf_we_o | output | 1 | Buffer write strobe |
| buf_re_o | output | 1 | Buffer read strobe |
| buf_wdata_o | output | 16 | Write data to the buffer storage |
| buf_rdata_i | input | 16 | Read data from the buffer storage |
| irq_o | output | 1 | Interrupt request, active high |
| dma_req_o | output | 1 | DMA request, active high |

## Verification
Random sparse set pulses are mixed with random enable words, random clear patterns and mode flips. This separates the interrupt output from the DMA output: a flag that is set but not enabled must raise only the DMA line. Directed cases put a set and a clear on the same bit in the same cycle, which shows whether the set wins over the clear. Buffer-window reads and writes at random endpoints check the one-hot select and the read return. They also show that window traffic and unmapped addresses leave the registers untouched.

// File: rtl/ep_notify_pkg.sv
package ep_notify_pkg;
  typedef enum logic {
    NOTIFY_IRQ = 1'b0,
    NOTIFY_DMA = 1'b1
  } notify_mode_e;

  localparam int REG_CTRL   = 0;
  localparam int REG_MASK   = 1;
  localparam int REG_STATUS = 2;
endpackage

// File: rtl/ep_addr_decode.sv
module ep_addr_decode #(
  parameter int NUM_EP   = 16,
  parameter int WORD_W   = 5,
  parameter int EP_IDX_W = $clog2(NUM_EP),
  parameter int ADDR_W   = 1 + EP_IDX_W + WORD_W
) (
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              buf_hit_o,
  output logic              wr_ctrl_o,
  output logic              wr_mask_o,
  output logic              wr_status_o,
  output logic [NUM_EP-1:0] buf_sel_o,
  output logic [WORD_W-1:0] buf_word_o,
  output logic              buf_we_o,
  output logic              buf_re_o
);
  import ep_notify_pkg::*;

  logic reg_wr;

  assign buf_hit_o   = cs_i && addr_i[ADDR_W-1];
  assign reg_wr      = cs_i && we_i && !addr_i[ADDR_W-1];
  assign wr_ctrl_o   = reg_wr && (addr_i == ADDR_W'(REG_CTRL));
  assign wr_mask_o   = reg_wr && (addr_i == ADDR_W'(REG_MASK));
  assign wr_status_o = reg_wr && (addr_i == ADDR_W'(REG_STATUS));
  assign buf_word_o  = addr_i[WORD_W-1:0];
  assign buf_we_o    = buf_hit_o && we_i;
  assign buf_re_o    = buf_hit_o && !we_i;

  for (genvar g = 0; g < NUM_EP; g++) begin : g_sel
    assign buf_sel_o[g] = buf_hit_o && (addr_i[WORD_W +: EP_IDX_W] == EP_IDX_W'(g));
  end
endmodule

// File: rtl/ep_ready_flags.sv
module ep_ready_flags #(
  parameter int NUM_EP = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EP-1:0] set_i,
  input  logic [NUM_EP-1:0] clr_i,
  output logic [NUM_EP-1:0] ready_o
);
  for (genvar g = 0; g < NUM_EP; g++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       ready_o[g] <= 1'b0;
      else if (set_i[g]) ready_o[g] <= 1'b1;  // set beats clear
      else if (clr_i[g]) ready_o[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/ep_notify_out.sv
module ep_notify_out #(
  parameter int NUM_EP = 16
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  ep_notify_pkg::notify_mode_e mode_i,
  input  logic [NUM_EP-1:0]          ready_i,
  input  logic [NUM_EP-1:0]          mask_i,
  output logic                       irq_o,
  output logic                       dma_req_o
);
  import ep_notify_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o     <= 1'b0;
      dma_req_o <= 1'b0;
    end else begin
      irq_o     <= (mode_i == NOTIFY_IRQ) && |(ready_i & mask_i);
      dma_req_o <= (mode_i == NOTIFY_DMA) && |ready_i;
    end
  end
endmodule

// File: rtl/ep_ready_notifier.sv
module ep_ready_notifier #(
  parameter int NUM_EP   = 16,
  parameter int DATA_W   = 16,
  parameter int WORD_W   = 5,
  parameter int EP_IDX_W = $clog2(NUM_EP),
  parameter int ADDR_W   = 1 + EP_IDX_W + WORD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_EP-1:0] ready_set_i,
  output logic [NUM_EP-1:0] buf_sel_o,
  output logic [WORD_W-1:0] buf_word_o,
  output logic              buf_we_o,
  output logic              buf_re_o,
  output logic [DATA_W-1:0] buf_wdata_o,
  input  logic [DATA_W-1:0] buf_rdata_i,
  output logic              irq_o,
  output logic              dma_req_o
);
  import ep_notify_pkg::*;

  logic              buf_hit, wr_ctrl, wr_mask, wr_status;
  logic [NUM_EP-1:0] ready_q, mask_q, clr_vec;
  notify_mode_e      mode_q;
  logic [DATA_W-1:0] rd_mux;

  ep_addr_decode #(.NUM_EP(NUM_EP), .WORD_W(WORD_W), .EP_IDX_W(EP_IDX_W), .ADDR_W(ADDR_W)) u_dec (
    .cs_i(cs_i), .we_i(we_i), .addr_i(addr_i),
    .buf_hit_o(buf_hit), .wr_ctrl_o(wr_ctrl), .wr_mask_o(wr_mask), .wr_status_o(wr_status),
    .buf_sel_o(buf_sel_o), .buf_word_o(buf_word_o), .buf_we_o(buf_we_o), .buf_re_o(buf_re_o)
  );

  assign clr_vec     = wr_status ? wdata_i[NUM_EP-1:0] : '0;
  assign buf_wdata_o = wdata_i;

  ep_ready_flags #(.NUM_EP(NUM_EP)) u_flags (
    .clk_i(clk_i), .rst_ni(rst_ni), .set_i(ready_set_i), .clr_i(clr_vec), .ready_o(ready_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= NOTIFY_IRQ;
      mask_q <= '0;
    end else begin
      if (wr_ctrl) mode_q <= notify_mode_e'(wdata_i[0]);
      if (wr_mask) mask_q <= wdata_i[NUM_EP-1:0];
    end
  end

  ep_notify_out #(.NUM_EP(NUM_EP)) u_out (
    .clk_i(clk_i), .rst_ni(rst_ni), .mode_i(mode_q), .ready_i(ready_q), .mask_i(mask_q),
    .irq_o(irq_o), .dma_req_o(dma_req_o)
  );

  always_comb begin
    rd_mux = '0;
    if (buf_hit)                               rd_mux = buf_rdata_i;
    else if (addr_i == ADDR_W'(REG_CTRL))      rd_mux = DATA_W'(mode_q);
    else if (addr_i == ADDR_W'(REG_MASK))      rd_mux = DATA_W'(mask_q);
    else if (addr_i == ADDR_W'(REG_STATUS))    rd_mux = DATA_W'(ready_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             rdata_o <= '0;
    else if (cs_i && !we_i)  rdata_o <= rd_mux;
  end
endmodule

// File: rtl/ep_notify_chk.sv
module ep_notify_chk #(
  parameter int NUM_EP = 16,
  parameter int ADDR_W = 10
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NUM_EP-1:0] ready_set_i,
  input logic [NUM_EP-1:0] ready_q,
  input logic              mode_q,
  input logic [NUM_EP-1:0] buf_sel_o,
  input logic              irq_o,
  input logic              dma_req_o
);
  logic status_wr;
  assign status_wr = cs_i && we_i && (addr_i == ADDR_W'(2));

  AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_set_i != '0) |=> ((ready_q & $past(ready_set_i)) == $past(ready_set_i))); // R4

  AST_NO_SILENT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !status_wr |=> (($past(ready_q) & ~ready_q) == '0)); // R3

  AST_IRQ_QUIET_IN_DMA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_q |=> !irq_o); // R6

  AST_DMA_QUIET_IN_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mode_q |=> !dma_req_o); // R5

  AST_DMA_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_q == '0) |=> !dma_req_o); // R6

  AST_SEL_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(buf_sel_o)); // R8
endmodule

bind ep_ready_notifier ep_notify_chk #(.NUM_EP(NUM_EP), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_i(cs_i), .we_i(we_i), .addr_i(addr_i),
  .ready_set_i(ready_set_i), .ready_q(ready_q), .mode_q(mode_q),
  .buf_sel_o(buf_sel_o), .irq_o(irq_o), .dma_req_o(dma_req_o)
);

// File: tb/sim_ep_ready_notifier.sv
module sim_ep_ready_notifier;
  localparam int NE = 16;
  localparam int DW = 16;
  localparam int AW = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs = 1'b0, we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0, rdata, buf_wdata, buf_rdata;
  logic [NE-1:0] set = '0, buf_sel;
  logic [4:0] buf_word;
  logic buf_we, buf_re, irq, dma;

  int checks = 0, fails = 0;
  logic [NE-1:0] m_ready = '0, m_mask = '0;
  logic m_dma = 1'b0;

  always #5 clk = ~clk;

  assign buf_rdata = DW'(buf_sel) ^ DW'(buf_word);

  ep_ready_notifier u0 (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .ready_set_i(set), .buf_sel_o(buf_sel), .buf_word_o(buf_word),
    .buf_we_o(buf_we), .buf_re_o(buf_re), .buf_wdata_o(buf_wdata), .buf_rdata_i(buf_rdata),
    .irq_o(irq), .dma_req_o(dma)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return !m_dma && |(m_ready & m_mask);
  endfunction

  function automatic logic exp_dma();
    return m_dma && |m_ready;
  endfunction

  task automatic bus_wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic [NE-1:0] s);
    cs = 1'b1; we = 1'b1; addr = a; wdata = d; set = s;
    @(posedge clk); @(negedge clk);
    cs = 1'b0; we = 1'b0; set = '0;
    if (!a[AW-1]) begin
      if (a == 10'h000) m_dma = d[0];
      if (a == 10'h001) m_mask = d;
      if (a == 10'h002) m_ready = m_ready & ~d;
    end
    m_ready = m_ready | s;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
    cs = 1'b1; we = 1'b0; addr = a;
    @(posedge clk); @(negedge clk);
    cs = 1'b0;
    d = rdata;
  endtask

  task automatic pulse(input logic [NE-1:0] s);
    set = s;
    @(posedge clk); @(negedge clk);
    set = '0;
    m_ready = m_ready | s;
  endtask

  task automatic check_notify(input string tag);
    @(posedge clk); @(negedge clk);
    chk({tag, " irq"}, irq, exp_irq());
    chk({tag, " dma"}, dma, exp_dma());
  endtask

  task automatic check_regs(input string tag);
    logic [DW-1:0] d;
    bus_rd(10'h002, d); chk({tag, " status"}, d, m_ready);
    bus_rd(10'h001, d); chk({tag, " mask"}, d, m_mask);
    bus_rd(10'h000, d); chk({tag, " ctrl"}, d, DW'(m_dma));
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] d;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 irq", irq, 1'b0);
    chk("R1 dma", dma, 1'b0);
    check_regs("R1");

    // R2 set, R5 masked flag does not raise irq
    pulse(16'h0010);
    check_notify("R5 masked");
    check_regs("R2");
    bus_wr(10'h001, 16'h0010, '0);
    check_notify("R5 enabled");
    chk("R5 irq high", irq, 1'b1);

    // R3 write-1-clear, zero bits untouched
    pulse(16'h0101);
    bus_wr(10'h002, 16'h0100, '0);
    check_regs("R3");

    // R4 set and clear on same bit in same cycle
    bus_wr(10'h002, 16'h0010, 16'h0010);
    check_regs("R4");
    chk("R4 bit4", m_ready[4], 1'b1);

    // R5 irq falls only when every enabled flag is clear
    bus_wr(10'h002, 16'h0010, '0);
    check_notify("R5 clear");
    chk("R5 irq low", irq, 1'b0);

    // R6 DMA mode ignores mask
    bus_wr(10'h001, 16'h0000, '0);
    bus_wr(10'h000, 16'h0001, '0);
    check_notify("R6 dma");
    chk("R6 dma high", dma, 1'b1);
    bus_wr(10'h002, 16'hFFFF, '0);
    check_notify("R6 clear");
    chk("R6 dma low", dma, 1'b0);

    // R7 unmapped register reads 0, R9 writes there change nothing
    bus_wr(10'h003, 16'hFFFF, '0);
    bus_rd(10'h003, d); chk("R7 unmapped", d, 16'h0000);
    check_regs("R9 unmapped");

    // R8/R9 buffer window
    for (int i = 0; i < 24; i++) begin
      logic [3:0] ep = 4'($urandom);
      logic [4:0] wd = 5'($urandom);
      logic [AW-1:0] a = {1'b1, ep, wd};
      cs = 1'b1; we = 1'b1; addr = a; wdata = 16'($urandom);
      #1;
      chk("R8 sel wr", buf_sel, 16'(1) << ep);
      chk("R8 word", buf_word, wd);
      chk("R8 we/re", {buf_we, buf_re}, 2'b10);
      chk("R8 wdata", buf_wdata, wdata);
      @(posedge clk); @(negedge clk);
      cs = 1'b0; we = 1'b0;
      bus_rd(a, d);
      chk("R8 rd", d, (16'(1) << ep) ^ 16'(wd));
    end
    #1;
    chk("R9 idle sel", {buf_sel, buf_we, buf_re}, '0);
    check_regs("R9 window");

    // random mix
    for (int i = 0; i < 400; i++) begin
      case ($urandom % 6)
        0: pulse(16'($urandom & $urandom & $urandom));
        1: bus_wr(10'h002, 16'($urandom & $urandom), '0);
        2: bus_wr(10'h001, 16'($urandom), '0);
        3: bus_wr(10'h000, 16'($urandom % 2), '0);
        4: begin
             logic [NE-1:0] s = 16'($urandom & $urandom);
             bus_wr(10'h002, 16'($urandom) | s, s); // R4
           end
        default: bus_wr({1'b1, 9'($urandom)}, 16'($urandom), '0); // R9
      endcase
      check_notify("R5/R6 rand");
      if (i % 20 == 0) check_regs("R2/R3 rand");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule